// File: doc/BRIEF.md
# Pulse Timekeeper with Width Classification

This block keeps the instrument's sense of time. A free-running counter, 24 bits wide by default, advances on every system clock (16.78 MHz in the target system). Two raw timing pulse lines come in from outside. Each line is synchronised and then passed through a glitch filter. A width meter then decides whether the filtered pulse was a spin pulse, a once-per-second pulse, or neither. The decision depends only on the measured width, not on which line carried the pulse.

Every qualified pulse latches the counter into the timestamp register for its class and raises a one-cycle flag. The same counter drives a periodic processor interrupt and a periodic buffer swap tick. A separate counter issues a watchdog reset pulse if the processor stops sending kick strobes.

Top module: `pulse_timekeeper`

## Requirements
- R1: A raw level on a pulse line is accepted only after it has been sampled on FILT_LEN (default 4, about 238 ns at 16.78 MHz) consecutive clock edges after the two-stage synchroniser. A high pulse lasting fewer edges produces no event, and a low dip of fewer edges inside a pulse does not split it. Inputs are active high.
- R2: Widths are measured on the filtered level. A width from SPIN_MIN (64) to PPS_MIN-1 (1023) clocks is a spin pulse. A width of PPS_MIN (1024) clocks or more is a once-per-second pulse. A shorter width gives no event.
- R3: `time_now` increments by one on every clock after reset. It returns from all ones to zero with no flag of any kind. During reset it holds zero.
- R4: A pulse sampled high on H consecutive edges raises the flag of its class for exactly one cycle, starting on the seventh edge after the last high sample. The matching stamp then equals `time_now - 1` (modulo 2^CNT_W). The stamp holds its value until the next event of the same class.
- R5: `irq` is high for one cycle whenever a spin or once-per-second flag is high. It is also high whenever `time_now` has all of its IRQ_BITS low bits at zero after a count.
- R6: A kick strobe sampled at edge k clears the watchdog. If no further kick arrives, `wd_reset` is high for exactly the one cycle after edge k+2^WD_BITS, and then again every 2^WD_BITS cycles. Kicks spaced closer than that keep it low.
- R7: `swap_tick` is high for one cycle exactly when `time_now` has its SWAP_BITS low bits at zero after a count, including at the counter wrap.
- R8: Both lines are filtered and classified independently. Either line may carry either class, and pulses overlapping on the two lines each produce their own event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_raw | input | NLINES | Raw asynchronous timing pulse lines, active high |
| wd_kick | input | 1 | Watchdog kick strobe from the processor |
| time_now | output | CNT_W | Current timebase count |
| spin_stamp | output | CNT_W | Count latched at the last spin pulse |
| pps_stamp | output | CNT_W | Count latched at the last once-per-second pulse |
| spin_flag | output | 1 | One-cycle spin pulse event |
| pps_flag | output | 1 | One-cycle once-per-second event |
| irq | output | 1 | One-cycle processor interrupt |
| wd_reset | output | 1 | One-cycle watchdog reset |
| swap_tick | output | 1 | One-cycle DMA buffer swap tick |

## Verification
A wrong filter or width counter shows up at the ports as a class flag that is missing, spurious or misplaced by whole cycles. The bench pins each event to a single expected edge, so an off-by-one error in any pipeline stage is caught at the first pulse near a width boundary. A counter fault breaks the per-cycle step check at once, and a swap or interrupt fault is caught at the next period boundary. A watchdog counter off by one fires a cycle early or late relative to the last kick, and this is seen at its first expiry.

// File: rtl/tk_pkg.sv
// Shared types for the pulse timekeeper.
package tk_pkg;
    // Outcome of a width measurement on one filtered line.
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_SPIN = 2'd1,
        CLS_PPS  = 2'd2
    } tk_class_e;
endpackage

// File: rtl/tk_glitch_filter.sv
// Two-flop synchroniser followed by a persistence filter.
// The output takes a new level only after the synchronised input has
// differed from it on FILT_LEN consecutive edges.
// Assumes FILT_LEN >= 2 and an asynchronous, active-high raw input.
module tk_glitch_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int RW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [RW-1:0] RUN_LAST = RW'(FILT_LEN - 1);

    logic [1:0]    sync_q;
    logic [RW-1:0] run_q;

    // Bring the raw line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], raw_i};
    end

    // Count disagreeing samples and flip once enough have been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            clean_o <= 1'b0;
        end else if (sync_q[1] == clean_o) begin
            run_q <= '0;
        end else if (run_q == RUN_LAST) begin
            run_q   <= '0;
            clean_o <= sync_q[1];
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R1: a new output level must have been present on the last two samples.
    p_filter_settled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_o != $past(clean_o)) |-> ($past(sync_q[1]) == clean_o && $past(sync_q[1], 2) == clean_o))
        else $error("filter changed without a settled input");
endmodule

// File: rtl/tk_width_class.sv
// Measures the high time of a filtered line and classifies it at the
// falling edge: spin for SPIN_MIN..PPS_MIN-1 clocks, once-per-second for
// PPS_MIN or more, nothing otherwise. The result is valid for one cycle.
// Assumes SPIN_MIN < PPS_MIN.
module tk_width_class
    import tk_pkg::*;
#(
    parameter int SPIN_MIN = 64,
    parameter int PPS_MIN  = 1024
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level_i,
    output tk_class_e class_o
);
    localparam int WCW = $clog2(PPS_MIN + 1);
    localparam logic [WCW-1:0] SPIN_W = WCW'(SPIN_MIN);
    localparam logic [WCW-1:0] PPS_W  = WCW'(PPS_MIN);

    logic [WCW-1:0] width_q;

    // Count high clocks, saturating at the once-per-second threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !level_i) width_q <= '0;
        else if (width_q != PPS_W) width_q <= width_q + 1'b1;
    end

    // Decide the class in the first low cycle after a high stretch.
    always_comb begin
        class_o = CLS_NONE;
        if (!level_i && width_q != '0) begin
            if (width_q >= PPS_W)       class_o = CLS_PPS;
            else if (width_q >= SPIN_W) class_o = CLS_SPIN;
        end
    end

    // R2: a verdict can only follow a high input and lasts one cycle.
    p_verdict_after_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (class_o != CLS_NONE) |-> $past(level_i))
        else $error("class reported without a preceding high level");
    p_verdict_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (class_o != CLS_NONE) |=> (class_o == CLS_NONE))
        else $error("class held for more than one cycle");
endmodule

// File: rtl/tk_timebase.sv
// Free-running counter with a periodic interrupt request (combinational,
// registered by the parent) and a registered buffer swap tick.
// Assumes IRQ_BITS and SWAP_BITS do not exceed CNT_W.
module tk_timebase #(
    parameter int CNT_W     = 24,
    parameter int IRQ_BITS  = 14,
    parameter int SWAP_BITS = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_due_o,
    output logic             swap_tick_o
);
    // Advance the timebase; wraps silently.
    always_ff @(posedge clk) begin
        if (!rst_n) count_o <= '0;
        else        count_o <= count_o + 1'b1;
    end

    // Swap tick follows the count that rolls the low field to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) swap_tick_o <= 1'b0;
        else        swap_tick_o <= &count_o[SWAP_BITS-1:0];
    end

    assign irq_due_o = &count_o[IRQ_BITS-1:0];

    // R3: the count steps by exactly one on every clock out of reset.
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count_o == $past(count_o) + 1'b1))
        else $error("timebase did not step by one");
    // R7: a swap tick coincides with a zero low field.
    p_swap_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        swap_tick_o |-> (count_o[SWAP_BITS-1:0] == '0))
        else $error("swap tick off its boundary");
endmodule

// File: rtl/tk_watchdog.sv
// Issues a one-cycle reset pulse when 2^WD_BITS clocks pass without a
// kick strobe; restarts its window after each pulse or kick.
module tk_watchdog #(
    parameter int WD_BITS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic wd_reset_o
);
    logic [WD_BITS-1:0] idle_q;

    // Count idle clocks and fire at the end of the window.
    always_ff @(posedge clk) begin
        if (!rst_n || kick_i) begin
            idle_q     <= '0;
            wd_reset_o <= 1'b0;
        end else if (&idle_q) begin
            idle_q     <= '0;
            wd_reset_o <= 1'b1;
        end else begin
            idle_q     <= idle_q + 1'b1;
            wd_reset_o <= 1'b0;
        end
    end

    // R6: a kick always suppresses the next cycle's reset pulse.
    p_kick_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> !wd_reset_o)
        else $error("watchdog fired right after a kick");
    // R6: the reset is a single-cycle pulse.
    p_wd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_o |=> !wd_reset_o)
        else $error("watchdog pulse too long");
endmodule

// File: rtl/pulse_timekeeper.sv
// Pulse timekeeper top: per-line filter and width classifier, timestamp
// capture by class, interrupt merge, watchdog and swap tick.
// Assumes pulses of one class on different lines rarely coincide; if they
// do, a single flag and stamp are produced for that cycle.
module pulse_timekeeper
    import tk_pkg::*;
#(
    parameter int NLINES    = 2,
    parameter int CNT_W     = 24,
    parameter int FILT_LEN  = 4,
    parameter int SPIN_MIN  = 64,
    parameter int PPS_MIN   = 1024,
    parameter int WD_BITS   = 24,
    parameter int IRQ_BITS  = 14,
    parameter int SWAP_BITS = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] pulse_raw,
    input  logic              wd_kick,
    output logic [CNT_W-1:0]  time_now,
    output logic [CNT_W-1:0]  spin_stamp,
    output logic [CNT_W-1:0]  pps_stamp,
    output logic              spin_flag,
    output logic              pps_flag,
    output logic              irq,
    output logic              wd_reset,
    output logic              swap_tick
);
    logic [NLINES-1:0] clean;
    tk_class_e         line_cls [NLINES];
    logic              spin_hit, pps_hit, irq_due;

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        tk_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .raw_i(pulse_raw[g]), .clean_o(clean[g])
        );
        tk_width_class #(.SPIN_MIN(SPIN_MIN), .PPS_MIN(PPS_MIN)) u_cls (
            .clk(clk), .rst_n(rst_n), .level_i(clean[g]), .class_o(line_cls[g])
        );
    end

    tk_timebase #(.CNT_W(CNT_W), .IRQ_BITS(IRQ_BITS), .SWAP_BITS(SWAP_BITS)) u_tb (
        .clk(clk), .rst_n(rst_n), .count_o(time_now),
        .irq_due_o(irq_due), .swap_tick_o(swap_tick)
    );

    tk_watchdog #(.WD_BITS(WD_BITS)) u_wd (
        .clk(clk), .rst_n(rst_n), .kick_i(wd_kick), .wd_reset_o(wd_reset)
    );

    // Merge the per-line verdicts into one hit per class.
    always_comb begin
        spin_hit = 1'b0;
        pps_hit  = 1'b0;
        for (int i = 0; i < NLINES; i++) begin
            spin_hit = spin_hit | (line_cls[i] == CLS_SPIN);
            pps_hit  = pps_hit  | (line_cls[i] == CLS_PPS);
        end
    end

    // Latch stamps and raise flags and the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spin_flag  <= 1'b0;
            pps_flag   <= 1'b0;
            irq        <= 1'b0;
            spin_stamp <= '0;
            pps_stamp  <= '0;
        end else begin
            spin_flag <= spin_hit;
            pps_flag  <= pps_hit;
            irq       <= spin_hit | pps_hit | irq_due;
            if (spin_hit) spin_stamp <= time_now;
            if (pps_hit)  pps_stamp  <= time_now;
        end
    end

    // R4: stamps hold between events of their class.
    p_stamp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !spin_hit |=> $stable(spin_stamp))
        else $error("spin stamp moved without an event");
    // R4: a flagged stamp is the count one clock earlier.
    p_stamp_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pps_flag |-> (pps_stamp == time_now - 1'b1))
        else $error("pps stamp does not match the timebase");
    // R5: every event raises the interrupt.
    p_irq_on_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spin_flag || pps_flag) |-> irq)
        else $error("event without interrupt");
endmodule

// File: tb/pulse_timekeeper_test.sv
module pulse_timekeeper_test;
    localparam int NL = 2, CW = 16, IRQB = 9, SWB = 12, WDB = 8;

    logic          clk = 0, rst_n = 0, wd_kick = 0;
    logic [NL-1:0] pulse_raw = '0;
    logic [CW-1:0] time_now, spin_stamp, pps_stamp;
    logic          spin_flag, pps_flag, irq, wd_reset, swap_tick;

    int  checks = 0, errors = 0, edge_n = 0, last_kick = 0;
    bit  mon_en = 0, kick_en = 1, wd_guard = 1;
    logic [CW-1:0] prev_time = '0;
    bit  have_prev = 0;

    pulse_timekeeper #(.NLINES(NL), .CNT_W(CW), .WD_BITS(WDB),
                       .IRQ_BITS(IRQB), .SWAP_BITS(SWB)) uut (
        .clk(clk), .rst_n(rst_n), .pulse_raw(pulse_raw), .wd_kick(wd_kick),
        .time_now(time_now), .spin_stamp(spin_stamp), .pps_stamp(pps_stamp),
        .spin_flag(spin_flag), .pps_flag(pps_flag), .irq(irq),
        .wd_reset(wd_reset), .swap_tick(swap_tick)
    );

    always #5 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edge_n);
        end
    endtask

    // Expected class from a clean width: 0 none, 1 spin, 2 pps.
    function automatic int classify(input int w);
        if (w >= 1024) return 2;
        if (w >= 64)   return 1;
        return 0;
    endfunction

    // Background kicker every 64 edges.
    always @(negedge clk) begin
        if (kick_en && (edge_n % 64 == 0)) begin
            wd_kick   = 1;
            last_kick = edge_n + 1;
        end else wd_kick = 0;
    end

    // Per-cycle monitor for R3, R5, R6 (kicked), R7.
    always @(negedge clk) begin
        if (mon_en) begin
            if (have_prev)
                check(time_now == CW'(prev_time + 1'b1), "R3 step", time_now, CW'(prev_time + 1'b1));
            check(swap_tick == (time_now[SWB-1:0] == 0), "R7 swap", swap_tick, time_now[SWB-1:0] == 0);
            check(irq == (spin_flag | pps_flag | (time_now[IRQB-1:0] == 0)), "R5 irq", irq,
                  spin_flag | pps_flag | (time_now[IRQB-1:0] == 0));
            if (wd_guard) check(wd_reset == 0, "R6 kicked", wd_reset, 0);
            prev_time = time_now;
            have_prev = 1;
        end
    end

    task automatic wait_edge(input int n);
        while (edge_n < n) @(negedge clk);
    endtask

    // Watch a window: the given class at edge target, no flags elsewhere.
    task automatic expect_at(input int kind, input int target, input string req);
        while (edge_n < target + 3) begin
            @(negedge clk);
            if (edge_n == target) begin
                check(spin_flag == (kind == 1), req, spin_flag, kind == 1);
                check(pps_flag == (kind == 2), req, pps_flag, kind == 2);
                if (kind == 1) check(spin_stamp == CW'(time_now - 1'b1), "R4 spin stamp", spin_stamp, CW'(time_now - 1'b1));
                if (kind == 2) check(pps_stamp == CW'(time_now - 1'b1), "R4 pps stamp", pps_stamp, CW'(time_now - 1'b1));
            end else if (edge_n > target - 3) begin
                check(!spin_flag && !pps_flag, {req, " quiet"}, {spin_flag, pps_flag}, 0);
            end
        end
    endtask

    // Clean pulse on one line sampled high on w edges.
    task automatic pulse(input int line, input int w, input string req);
        int e0;
        @(negedge clk);
        e0 = edge_n + 1;
        pulse_raw[line] = 1;
        repeat (w) @(negedge clk);
        pulse_raw[line] = 0;
        expect_at(classify(w), e0 + w + 6, req);
    endtask

    initial begin : watchdog_timer
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int e0;
        logic [CW-1:0] sp_before;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        check(time_now == 0 && !spin_flag && !pps_flag && !irq && !wd_reset && !swap_tick,
              "R3 reset state", time_now, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        mon_en = 1;

        // Directed width and filter boundaries (R1, R2, R4).
        pulse(0, 3, "R1 short glitch");
        pulse(0, 4, "R1 min filtered, R2 too short");
        pulse(1, 63, "R2 below spin");
        pulse(0, 64, "R2 spin min");
        pulse(1, 1023, "R2 spin max");
        pulse(0, 1024, "R2 pps min");

        // R1: a 2-edge dip inside a 100-edge pulse is ignored.
        sp_before = spin_stamp;
        @(negedge clk);
        e0 = edge_n + 1;
        pulse_raw[1] = 1;
        repeat (50) @(negedge clk);
        pulse_raw[1] = 0;
        repeat (2) @(negedge clk);
        pulse_raw[1] = 1;
        repeat (48) @(negedge clk);
        pulse_raw[1] = 0;
        expect_at(1, e0 + 106, "R1 dip ignored");
        check(spin_stamp != sp_before, "R1 dip stamp updated", spin_stamp, sp_before);

        // R8: overlapping pulses on both lines, each classified on its own.
        @(negedge clk);
        e0 = edge_n + 1;
        pulse_raw = 2'b11;
        repeat (200) @(negedge clk);
        pulse_raw[0] = 0;
        expect_at(1, e0 + 206, "R8 line0 spin");
        wait_edge(e0 + 1499);
        pulse_raw[1] = 0;
        expect_at(2, e0 + 1506, "R8 line1 pps");

        // Random pulses on random lines.
        for (int i = 0; i < 30; i++) begin
            int cat = $urandom_range(3, 0);
            int w;
            case (cat)
                0: w = $urandom_range(3, 1);
                1: w = $urandom_range(63, 4);
                2: w = $urandom_range(1023, 64);
                default: w = $urandom_range(1400, 1024);
            endcase
            pulse($urandom_range(1, 0), w, "R2 random");
            repeat ($urandom_range(40, 5)) @(negedge clk);
        end

        // R6: stop kicking and watch the expiry points.
        while (edge_n % 64 != 10) @(negedge clk);
        kick_en = 0;
        wd_guard = 0;
        e0 = last_kick;
        wait_edge(e0 + 255);
        check(wd_reset == 0, "R6 before expiry", wd_reset, 0);
        @(negedge clk);
        check(wd_reset == 1, "R6 expiry", wd_reset, 1);
        @(negedge clk);
        check(wd_reset == 0, "R6 single pulse", wd_reset, 0);
        wait_edge(e0 + 512);
        check(wd_reset == 1, "R6 repeat expiry", wd_reset, 1);
        @(negedge clk);
        kick_en = 1;
        repeat (70) @(negedge clk);
        wd_guard = 1;

        // R3 / R7: counter wrap.
        while (time_now != {CW{1'b1}}) @(negedge clk);
        check(!spin_flag && !pps_flag, "R3 no wrap flag", {spin_flag, pps_flag}, 0);
        @(negedge clk);
        check(time_now == 0, "R3 wrap to zero", time_now, 0);
        check(swap_tick == 1, "R7 swap at wrap", swap_tick, 1);
        check(!spin_flag && !pps_flag, "R3 no wrap flag after", {spin_flag, pps_flag}, 0);
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule